// File: doc/BRIEF.md
# Per-Hart Software Interrupt Register Bank

This block holds one 32-bit software interrupt register for each hart in a cluster and drives one interrupt line per hart. Software pokes a hart's register to raise that hart's software interrupt. The registers sit on a simple 32-bit register bus. Hart `i`'s register lives at byte offset `4*i`, and output bit `i` is its interrupt line. Reads are answered one cycle after the request.

A static mode parameter selects one of two behaviours. In machine mode, bit 0 of each register is a pending flag: software can read it, set it and clear it, and reset clears it. In supervisor mode, each register is a write-only trigger. Writing 1 raises the line, writing 0 does nothing, reads return zero and reset leaves the lines alone. The hart side drops a raised line through a per-hart acknowledge input.

Top module: `swi_bank`

## Requirements
- R1: Hart `i`'s register is at byte offset `4*i`. A write to a word-aligned offset at or above `4*NUM_HARTS` changes no output, and a read there returns zero.
- R2: Only bit 0 of the write data is used. A full-word write with bit 0 = 1 raises that hart's line on the clock edge that takes the write, in both modes.
- R3: In machine mode, a full-word write with bit 0 = 0 lowers that hart's line on the clock edge that takes the write.
- R4: Each read request produces `rd_valid` high for exactly the next cycle. In machine mode, `rd_data` then holds the hart's pending state in bit 0 and zero in bits 31:1.
- R5: In machine mode, reset lowers every interrupt line.
- R6: In supervisor mode, every read returns zero.
- R7: In supervisor mode, writing bit 0 = 0 leaves the line unchanged.
- R8: In supervisor mode, a high `sw_clear[i]` lowers line `i` on the next edge. If a write of 1 to the same hart arrives in the same cycle, the write wins and the line stays high.
- R9: In supervisor mode, reset leaves the interrupt lines unchanged.
- R10: A write whose byte strobes are not all set, or whose address is not 4-byte aligned, changes no output. A read of that kind returns zero.
- R11: A write changes only the addressed hart's line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset within the bank |
| bus_wdata | input | 32 | Write data; only bit 0 is used |
| bus_strb | input | 4 | Byte strobes; only 4'b1111 is a valid access |
| sw_clear | input | NUM_HARTS | Per-hart acknowledge from the hart side (supervisor mode only) |
| rd_valid | output | 1 | Read response valid, one cycle after the request |
| rd_data | output | 32 | Read response data |
| swi_irq | output | NUM_HARTS | Registered software interrupt line per hart |

## Verification
On every cycle, properties check the following. A valid write of 1 raises the addressed line, and in machine mode a write of 0 lowers it. In supervisor mode a write of 0 leaves the line as it was, and an acknowledge lowers it when no set competes. Rejected or out-of-range writes leave all lines unchanged, and every read request gets a response on the next cycle.

Some behaviours only the bench scenarios can show. These are the value returned by a read, the effect of reset in each mode (cleared in machine mode, preserved in supervisor mode), and the set-over-acknowledge priority. Two instances, one per mode, share one random stimulus stream so that the two modes can be compared against each other.

// File: rtl/swi_pkg.sv
package swi_pkg;
  typedef enum logic {
    MODE_MACHINE    = 1'b0,
    MODE_SUPERVISOR = 1'b1
  } swi_mode_e;

  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } swi_acc_e;

  localparam int unsigned WORD_BITS = 32;
  localparam logic [3:0]  FULL_STRB = 4'b1111;
endpackage

// File: rtl/swi_rst_sync.sv
module swi_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= stage_d;
    end
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/swi_decode.sv
module swi_decode #(
  parameter int unsigned NUM_HARTS = 4,
  parameter int unsigned ADDR_W    = 8
) (
  input  logic                 bus_valid,
  input  logic                 bus_write,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [3:0]           bus_strb,
  output logic                 rd_req,
  output logic [NUM_HARTS-1:0] wr_sel,
  output logic [NUM_HARTS-1:0] rd_sel
);
  import swi_pkg::*;

  localparam int unsigned WORD_W = ADDR_W - 2;

  swi_acc_e          kind;
  logic [WORD_W-1:0] word_idx;
  logic              aligned;
  logic              full_word;
  logic              in_range;
  logic              good;

  always_comb begin
    word_idx  = bus_addr[ADDR_W-1:2];
    aligned   = (bus_addr[1:0] == 2'b00);
    full_word = (bus_strb == FULL_STRB);
    in_range  = ({1'b0, word_idx} < (WORD_W+1)'(NUM_HARTS));
    good      = bus_valid && aligned && full_word && in_range;
    if (!bus_valid) begin
      kind = ACC_NONE;
    end else if (bus_write) begin
      kind = ACC_WRITE;
    end else begin
      kind = ACC_READ;
    end
    rd_req = (kind == ACC_READ);
  end

  for (genvar g = 0; g < NUM_HARTS; g++) begin : g_sel
    logic match;
    assign match     = good && (word_idx == WORD_W'(g));
    assign wr_sel[g] = match && (kind == ACC_WRITE);
    assign rd_sel[g] = match && (kind == ACC_READ);
  end
endmodule

// File: rtl/swi_cell.sv
module swi_cell #(
  parameter swi_pkg::swi_mode_e MODE = swi_pkg::MODE_MACHINE
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_req,
  input  logic zero_req,
  input  logic ack,
  output logic pend
);
  import swi_pkg::*;

  logic pend_q;
  logic pend_d;
  logic pend_en;

  if (MODE == MODE_MACHINE) begin : g_machine
    logic unused_ack;
    assign unused_ack = ack;

    always_comb begin
      pend_en = set_req || zero_req;
      pend_d  = set_req;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_q <= 1'b0;
      end else if (pend_en) begin
        pend_q <= pend_d;
      end
    end
  end else begin : g_supervisor
    logic unused_sup;
    assign unused_sup = zero_req ^ rst_n;

    always_comb begin
      pend_en = set_req || ack;
      pend_d  = set_req;
    end

    always_ff @(posedge clk) begin
      if (pend_en) begin
        pend_q <= pend_d;
      end
    end
  end

  assign pend = pend_q;
endmodule

// File: rtl/swi_readback.sv
module swi_readback #(
  parameter int unsigned        NUM_HARTS = 4,
  parameter swi_pkg::swi_mode_e MODE      = swi_pkg::MODE_MACHINE
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rd_req,
  input  logic [NUM_HARTS-1:0] rd_sel,
  input  logic [NUM_HARTS-1:0] pend,
  output logic                 rd_valid,
  output logic [31:0]          rd_data
);
  import swi_pkg::*;

  localparam logic READABLE = (MODE == MODE_MACHINE);

  logic        valid_q;
  logic        valid_d;
  logic [31:0] data_q;
  logic [31:0] data_d;
  logic        pick;

  always_comb begin
    pick    = |(rd_sel & pend);
    valid_d = rd_req;
    data_d  = {31'b0, pick & READABLE};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
    end else begin
      valid_q <= valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (rd_req) begin
      data_q <= data_d;
    end
  end

  assign rd_valid = valid_q;
  assign rd_data  = data_q;
endmodule

// File: rtl/swi_bank.sv
module swi_bank #(
  parameter int unsigned        NUM_HARTS = 4,
  parameter int unsigned        ADDR_W    = 8,
  parameter swi_pkg::swi_mode_e MODE      = swi_pkg::MODE_MACHINE
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_valid,
  input  logic                 bus_write,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [31:0]          bus_wdata,
  input  logic [3:0]           bus_strb,
  input  logic [NUM_HARTS-1:0] sw_clear,
  output logic                 rd_valid,
  output logic [31:0]          rd_data,
  output logic [NUM_HARTS-1:0] swi_irq
);
  logic                 rst_sync_n;
  logic                 rd_req;
  logic [NUM_HARTS-1:0] wr_sel;
  logic [NUM_HARTS-1:0] rd_sel;
  logic [NUM_HARTS-1:0] pend;
  logic                 wr_bit;
  logic                 unused_wdata;

  assign wr_bit       = bus_wdata[0];
  assign unused_wdata = ^bus_wdata[31:1];

  swi_rst_sync i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  swi_decode #(
    .NUM_HARTS (NUM_HARTS),
    .ADDR_W    (ADDR_W)
  ) i_decode (
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_strb  (bus_strb),
    .rd_req    (rd_req),
    .wr_sel    (wr_sel),
    .rd_sel    (rd_sel)
  );

  for (genvar g = 0; g < NUM_HARTS; g++) begin : g_hart
    swi_cell #(
      .MODE (MODE)
    ) i_cell (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .set_req  (wr_sel[g] && wr_bit),
      .zero_req (wr_sel[g] && !wr_bit),
      .ack      (sw_clear[g]),
      .pend     (pend[g])
    );
  end

  swi_readback #(
    .NUM_HARTS (NUM_HARTS),
    .MODE      (MODE)
  ) i_readback (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .rd_req   (rd_req),
    .rd_sel   (rd_sel),
    .pend     (pend),
    .rd_valid (rd_valid),
    .rd_data  (rd_data)
  );

  assign swi_irq = pend;
endmodule

// File: rtl/swi_bank_chk.sv
module swi_bank_chk #(
  parameter int unsigned        NUM_HARTS = 4,
  parameter int unsigned        ADDR_W    = 8,
  parameter swi_pkg::swi_mode_e MODE      = swi_pkg::MODE_MACHINE
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 bus_valid,
  input logic                 bus_write,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic                 wr_bit,
  input logic [3:0]           bus_strb,
  input logic [NUM_HARTS-1:0] sw_clear,
  input logic                 rd_valid,
  input logic [NUM_HARTS-1:0] swi_irq
);
  logic [NUM_HARTS-1:0] hit;

  always_comb begin
    for (int i = 0; i < NUM_HARTS; i++) begin
      hit[i] = bus_valid && bus_write && (bus_strb == 4'hF) &&
               (bus_addr[1:0] == 2'b00) &&
               (int'(bus_addr[ADDR_W-1:2]) == i);
    end
  end

  // R1
  stray_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && (hit == '0) && (sw_clear == '0)) |=> $stable(swi_irq));

  // R4
  read_response_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write) |=> rd_valid);

  // R4
  no_spurious_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_valid && !bus_write) |=> !rd_valid);

  for (genvar g = 0; g < NUM_HARTS; g++) begin : g_chk
    // R2
    set_raises_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit[g] && wr_bit) |=> swi_irq[g]);

    if (MODE == swi_pkg::MODE_MACHINE) begin : g_m
      // R3
      zero_lowers_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit[g] && !wr_bit) |=> !swi_irq[g]);
    end else begin : g_s
      // R7
      zero_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit[g] && !wr_bit && !sw_clear[g]) |=> $stable(swi_irq[g]));
      // R8
      ack_lowers_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_clear[g] && !(hit[g] && wr_bit)) |=> !swi_irq[g]);
    end
  end
endmodule

bind swi_bank swi_bank_chk #(
  .NUM_HARTS (NUM_HARTS),
  .ADDR_W    (ADDR_W),
  .MODE      (MODE)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .bus_valid (bus_valid),
  .bus_write (bus_write),
  .bus_addr  (bus_addr),
  .wr_bit    (bus_wdata[0]),
  .bus_strb  (bus_strb),
  .sw_clear  (sw_clear),
  .rd_valid  (rd_valid),
  .swi_irq   (swi_irq)
);

// File: tb/test_swi_bank.sv
`timescale 1ns/1ps
module test_swi_bank;
  localparam int N  = 4;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          bus_valid, bus_write;
  logic [AW-1:0] bus_addr;
  logic [31:0]   bus_wdata;
  logic [3:0]    bus_strb;
  logic [N-1:0]  sw_clear;
  logic          rdv_m, rdv_s;
  logic [31:0]   rdd_m, rdd_s;
  logic [N-1:0]  irq_m, irq_s;

  logic [N-1:0]  m_exp, s_exp;
  int            errors = 0;
  int            checks = 0;
  bit            done   = 0;

  always #2.5 clk = ~clk;

  swi_bank #(.NUM_HARTS(N), .ADDR_W(AW), .MODE(swi_pkg::MODE_MACHINE)) i_swi_bank (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_strb(bus_strb),
    .sw_clear(sw_clear), .rd_valid(rdv_m), .rd_data(rdd_m), .swi_irq(irq_m));

  swi_bank #(.NUM_HARTS(N), .ADDR_W(AW), .MODE(swi_pkg::MODE_SUPERVISOR)) i_swi_bank_sup (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_strb(bus_strb),
    .sw_clear(sw_clear), .rd_valid(rdv_s), .rd_data(rdd_s), .swi_irq(irq_s));

  function automatic bit acc_ok(logic [AW-1:0] a, logic [3:0] s);
    return (s == 4'hF) && (a[1:0] == 2'b00) && (int'(a[AW-1:2]) < N);
  endfunction

  function automatic logic [N-1:0] hart_bit(logic [AW-1:0] a);
    logic [N-1:0] v;
    v = '0;
    for (int i = 0; i < N; i++) if (int'(a[AW-1:2]) == i) v[i] = 1'b1;
    return v;
  endfunction

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic idle();
    bus_valid = 0; bus_write = 0; bus_addr = '0; bus_wdata = '0;
    bus_strb = 4'hF; sw_clear = '0;
  endtask

  // One bus cycle, starting at a negedge; checks after the taking edge.
  task automatic op(string tag, bit wr, logic [AW-1:0] a, logic [31:0] d,
                    logic [3:0] s, logic [N-1:0] clr);
    logic [N-1:0] sel, set_v, zero_v;
    logic [31:0]  exp_rm;
    bit           ok;
    ok     = acc_ok(a, s);
    sel    = ok ? hart_bit(a) : '0;
    set_v  = (wr && d[0])  ? sel : '0;
    zero_v = (wr && !d[0]) ? sel : '0;
    exp_rm = {31'b0, |(sel & m_exp)};
    bus_valid = 1; bus_write = wr; bus_addr = a; bus_wdata = d;
    bus_strb = s; sw_clear = clr;
    @(posedge clk);
    #1;
    idle();
    m_exp = (m_exp & ~zero_v) | set_v;
    s_exp = (s_exp & ~clr) | set_v;
    check(tag, "machine irq", 32'(irq_m), 32'(m_exp));
    check(tag, "supervisor irq", 32'(irq_s), 32'(s_exp));
    if (!wr) begin
      check(tag, "rd_valid", {30'b0, rdv_m, rdv_s}, 32'h3);
      check(tag, "machine rd_data", rdd_m, exp_rm);
      check(tag, "supervisor rd_data", rdd_s, 32'h0);
    end
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    idle();
    rst_n = 0;
    m_exp = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    // R8: acknowledge everything to put the supervisor bank in a known state
    s_exp = '1;
    op("R8", 0, 8'h00, 32'h0, 4'hF, '1);
    // R5: reset state of machine bank
    check("R5", "machine irq after reset", 32'(irq_m), 32'h0);
    op("R5", 0, 8'h00, 32'h0, 4'hF, '0);
    // R2 / R11: raise hart 2 only
    op("R2", 1, 8'h08, 32'h1, 4'hF, '0);
    // R3 / R7: upper bits set, bit 0 clear
    op("R3", 1, 8'h08, 32'hFFFF_FFFE, 4'hF, '0);
    // R4 / R6: readback after a set with extra bits
    op("R11", 1, 8'h04, 32'h3, 4'hF, '0);
    op("R4", 0, 8'h04, 32'h0, 4'hF, '0);
    op("R6", 0, 8'h08, 32'h0, 4'hF, '0);
    // R1: beyond last hart
    op("R1", 1, 8'h10, 32'h1, 4'hF, '0);
    op("R1", 0, 8'h10, 32'h0, 4'hF, '0);
    // R10: misaligned and partial strobes
    op("R10", 1, 8'h0D, 32'h1, 4'hF, '0);
    op("R10", 1, 8'h0C, 32'h1, 4'h3, '0);
    op("R10", 0, 8'h05, 32'h0, 4'hF, '0);
    // R8: acknowledge hart 1, then set and acknowledge hart 3 together
    op("R8", 0, 8'h14, 32'h0, 4'hF, 4'b0010);
    op("R8", 1, 8'h0C, 32'h1, 4'hF, 4'b1000);
    // random mix
    for (int k = 0; k < 400; k++) begin
      logic [AW-1:0] a;
      logic [3:0]    s;
      logic [N-1:0]  c;
      bit            w;
      string         tag;
      a = AW'($urandom_range(0, (N + 2) * 4 - 1));
      if ($urandom_range(0, 7) != 0) a[1:0] = 2'b00;
      s = ($urandom_range(0, 9) == 0) ? 4'($urandom) : 4'hF;
      c = ($urandom_range(0, 3) == 0) ? N'($urandom) : '0;
      w = 1'($urandom);
      if (s != 4'hF || a[1:0] != 0) tag = "R10";
      else if (int'(a[AW-1:2]) >= N) tag = "R1";
      else if (w) tag = "R2/R3/R7";
      else tag = "R4/R6";
      op(tag, w, a, $urandom, s, c);
    end
    // R5 / R9: reset with all lines raised
    for (int h = 0; h < N; h++) op("R2", 1, AW'(h * 4), 32'h1, 4'hF, '0);
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    m_exp = '0;
    check("R5", "machine irq after second reset", 32'(irq_m), 32'h0);
    check("R9", "supervisor irq kept over reset", 32'(irq_s), 32'(s_exp));
    op("R9", 0, 8'h00, 32'h0, 4'hF, '0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule